// File: doc/BRIEF.md
# Full-Duplex 16-Bit SPI Register Slave

This block sits between a host microcontroller's SPI master and a small bank of control registers. Every transaction is one 16-bit frame. The first four bits the host shifts in form a header: a two-bit register address, a bit that picks one of two feedback words for that address, and a read-only flag. The remaining twelve bits are the write data. While the command shifts in, the block shifts a return frame out on the same clocks. The return frame holds an echo of the last accepted header, followed by the twelve-bit feedback word that the incoming header selects.

The SPI pins are sampled by the block's system clock through synchronisers, so SCK must run well below the system clock. Nothing is committed while chip select is low. When chip select rises, the block checks the clock count. A frame with exactly 16 clocks and the read-only flag clear produces a one-cycle write strobe with the address and data. A frame with exactly 16 clocks and the read-only flag set writes nothing. Any other clock count raises a one-cycle clock-count failure pulse instead.

The register contents and their meaning live outside this block. Eight feedback words, one for each address and select pair, arrive on a flat input bus.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `wr_stb_o`, `clk_fail_o`, `spi_miso` and `spi_miso_oe` are all 0.
- R2: `spi_miso_oe` is 1 while chip select is low and 0 while it is high. `spi_miso` reads 0 whenever `spi_miso_oe` is 0.
- R3: Bits are taken MSB first on SCK rising edges. Of the 16 received bits, bits 15 and 14 are the address, bit 13 is the feedback select, bit 12 is the read-only flag and bits 11 to 0 are the write data.
- R4: For a 16-clock frame with bit 12 equal to 0, `wr_stb_o` pulses high for exactly one cycle, 3 clock cycles after chip select rises, with `wr_addr_o` = bits 15:14 and `wr_data_o` = bits 11:0.
- R5: For a 16-clock frame with bit 12 equal to 1, no write strobe and no failure pulse occur.
- R6: Response bits 11 to 0 are MSB first and change on SCK falling edges. They carry feedback word k = {bit15, bit14, bit13}, which is `fb_words_i[k*12 +: 12]`.
- R7: Response bits 15 to 12 echo bits 15 to 12 of the most recent frame that had exactly 16 clocks. They are 0 after reset.
- R8: A frame whose clock count is not 16 (including 0, 15 and 17) pulses `clk_fail_o` for one cycle, 3 cycles after chip select rises. It produces no write strobe and does not change the echoed header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_mosi | input | 1 | Command data from host |
| spi_miso | output | 1 | Response data to host |
| spi_miso_oe | output | 1 | Output enable for the response pad driver |
| fb_words_i | input | 96 | Eight 12-bit feedback words, index {address, select} |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 2 | Write address |
| wr_data_o | output | 12 | Write data |
| clk_fail_o | output | 1 | One-cycle clock-count failure pulse |

## Verification
Each pin passes through two synchroniser flops and one edge register. As a result, a write strobe or failure pulse appears exactly 3 system cycles after chip select rises. The bench timestamps every pulse against that cycle and checks that exactly one pulse occurred. A response bit settles within 3 system cycles of an SCK falling edge. The bench holds each SCK phase for 8 system cycles and reads `spi_miso` just before the rising edge, as a host would. The output enable is checked 8 cycles after each chip select change.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
    localparam int HDR_BITS   = 4;
    localparam int DATA_W     = 12;
    localparam int ADDR_W     = 2;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int NUM_FB     = 2 ** (ADDR_W + 1);
    localparam int FB_W       = NUM_FB * DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
    localparam int IDX_W      = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              fb_sel;
        logic              ro;
    } hdr_t;

    typedef struct packed {
        hdr_t              hdr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [IDX_W-1:0] fb_index(input hdr_t h);
        return {h.addr, h.fb_sel};
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign lvl_o = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= RST_VAL;
        else     last_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~last_q;
    assign fall_o = ~lvl_i & last_q;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_lvl,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              mosi_lvl,
    output hdr_t              hdr_now_o,
    output logic [CNT_W-1:0]  cnt_o,
    output hdr_t              last_hdr_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              fail_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    logic [FRAME_BITS-1:0] shift_q;
    frame_t                frm;

    assign frm       = frame_t'(shift_q);
    assign hdr_now_o = hdr_t'(shift_q[HDR_BITS-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q    <= '0;
            cnt_o      <= '0;
            last_hdr_o <= '0;
            wr_stb_o   <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            fail_o     <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            fail_o   <= 1'b0;
            if (cs_fall) begin
                shift_q <= '0;
                cnt_o   <= '0;
            end else if (!cs_n_lvl && sck_rise) begin
                shift_q <= {shift_q[FRAME_BITS-2:0], mosi_lvl};
                if (cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
            end
            if (cs_rise) begin
                if (cnt_o == CNT_FULL) begin
                    last_hdr_o <= frm.hdr;
                    if (!frm.hdr.ro) begin
                        wr_stb_o  <= 1'b1;
                        wr_addr_o <= frm.hdr.addr;
                        wr_data_o <= frm.data;
                    end
                end else begin
                    fail_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
    import spi_rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_lvl,
    input  logic              cs_fall,
    input  logic              sck_fall,
    input  logic [CNT_W-1:0]  cnt_i,
    input  hdr_t              hdr_now_i,
    input  hdr_t              last_hdr_i,
    input  logic [FB_W-1:0]   fb_words_i,
    output logic              miso_o,
    output logic              miso_oe_o
);
    localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_BITS);

    logic [DATA_W-1:0]     words [NUM_FB];
    logic [FRAME_BITS-1:0] tx_q;

    genvar w;
    generate
        for (w = 0; w < NUM_FB; w++) begin : g_word
            assign words[w] = fb_words_i[w*DATA_W +: DATA_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (cs_fall) begin
            tx_q <= {last_hdr_i, {DATA_W{1'b0}}};
        end else if (!cs_n_lvl && sck_fall) begin
            if (cnt_i == CNT_HDR) tx_q <= {words[fb_index(hdr_now_i)], {HDR_BITS{1'b0}}};
            else                  tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign miso_oe_o = ~cs_n_lvl;
    assign miso_o    = cs_n_lvl ? 1'b0 : tx_q[FRAME_BITS-1];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_rs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [FB_W-1:0]   fb_words_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              clk_fail_o
);
    logic [2:0]       pins_lvl;
    logic [1:0]       ctl_rise;
    logic [1:0]       ctl_fall;
    logic [CNT_W-1:0] bit_cnt;
    hdr_t             hdr_now;
    hdr_t             last_hdr;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i ({spi_cs_n, spi_sck, spi_mosi}),
        .lvl_o (pins_lvl)
    );

    spi_edge_det #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (pins_lvl[2:1]),
        .rise_o (ctl_rise),
        .fall_o (ctl_fall)
    );

    spi_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_n_lvl   (pins_lvl[2]),
        .cs_fall    (ctl_fall[1]),
        .cs_rise    (ctl_rise[1]),
        .sck_rise   (ctl_rise[0]),
        .mosi_lvl   (pins_lvl[0]),
        .hdr_now_o  (hdr_now),
        .cnt_o      (bit_cnt),
        .last_hdr_o (last_hdr),
        .wr_stb_o   (wr_stb_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .fail_o     (clk_fail_o)
    );

    spi_frame_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .cs_n_lvl   (pins_lvl[2]),
        .cs_fall    (ctl_fall[1]),
        .sck_fall   (ctl_fall[0]),
        .cnt_i      (bit_cnt),
        .hdr_now_i  (hdr_now),
        .last_hdr_i (last_hdr),
        .fb_words_i (fb_words_i),
        .miso_o     (spi_miso),
        .miso_oe_o  (spi_miso_oe)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic spi_miso_oe,
    input logic wr_stb_o,
    input logic clk_fail_o
);
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    p_fail_single_r8: assert property (@(posedge clk) disable iff (rst)
        clk_fail_o |=> !clk_fail_o);

    p_fail_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb_o && clk_fail_o));

    p_write_after_deselect_r4: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> $past(!spi_miso_oe));

    p_oe_follows_cs_r2: assert property (@(posedge clk) disable iff (rst)
        spi_miso_oe |-> $past(!spi_cs_n, 2));

    p_miso_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !spi_miso_oe |-> !spi_miso);
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .wr_stb_o    (wr_stb_o),
    .clk_fail_o  (clk_fail_o)
);

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [95:0] fb_words;
    logic        wr_stb;
    logic [1:0]  wr_addr;
    logic [11:0] wr_data;
    logic        clk_fail;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int stb_cnt = 0, stb_cyc = 0;
    int fail_cnt = 0, fail_cyc = 0;
    logic [1:0]  stb_addr;
    logic [11:0] stb_data;
    logic [3:0]  ref_hdr = 4'h0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    spi_reg_slave u_spi_reg_slave (
        .clk         (clk),
        .rst         (rst),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .fb_words_i  (fb_words),
        .wr_stb_o    (wr_stb),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .clk_fail_o  (clk_fail)
    );

    function automatic logic [11:0] fb_word(input int idx);
        return 12'h3C5 ^ 12'(idx * 12'h1A7);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            stb_cnt++; stb_cyc = cyc; stb_addr = wr_addr; stb_data = wr_data;
        end
        if (!rst && clk_fail) begin
            fail_cnt++; fail_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [15:0] cmd, input int nclk);
        logic [15:0] got;
        int s0, f0, base;
        bit valid;
        got = '0;
        s0 = stb_cnt;
        f0 = fail_cnt;
        valid = (nclk == 16);
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        chk(spi_miso_oe == 1'b1, "R2", "oe while selected", 32'(spi_miso_oe), 1);
        for (int i = 0; i < nclk; i++) begin
            spi_mosi = (i < 16) ? cmd[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 16) got[15-i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        base = cyc;
        repeat (8) @(negedge clk);
        chk(spi_miso_oe == 1'b0, "R2", "oe after deselect", 32'(spi_miso_oe), 0);
        chk(spi_miso == 1'b0, "R2", "miso after deselect", 32'(spi_miso), 0);
        if (valid) begin
            chk(got[15:12] == ref_hdr, "R7", "echoed header", 32'(got[15:12]), 32'(ref_hdr));
            chk(got[11:0] == fb_word(int'(cmd[15:13])), "R6", "feedback word",
                32'(got[11:0]), 32'(fb_word(int'(cmd[15:13]))));
            chk(fail_cnt == f0, "R5", "no failure on 16 clocks", 32'(fail_cnt - f0), 0);
            if (!cmd[12]) begin
                chk(stb_cnt == s0 + 1, "R4", "one strobe", 32'(stb_cnt - s0), 1);
                chk(stb_cyc == base + 3, "R4", "strobe cycle", 32'(stb_cyc - base), 3);
                chk(stb_addr == cmd[15:14], "R3", "write address", 32'(stb_addr), 32'(cmd[15:14]));
                chk(stb_data == cmd[11:0], "R3", "write data", 32'(stb_data), 32'(cmd[11:0]));
            end else begin
                chk(stb_cnt == s0, "R5", "read-only suppresses write", 32'(stb_cnt - s0), 0);
            end
            ref_hdr = cmd[15:12];
        end else begin
            chk(stb_cnt == s0, "R8", "no strobe on bad count", 32'(stb_cnt - s0), 0);
            chk(fail_cnt == f0 + 1, "R8", "one failure pulse", 32'(fail_cnt - f0), 1);
            chk(fail_cyc == base + 3, "R8", "failure cycle", 32'(fail_cyc - base), 3);
        end
    endtask

    initial begin
        for (int k = 0; k < 8; k++) fb_words[k*12 +: 12] = fb_word(k);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_stb == 1'b0, "R1", "strobe after reset", 32'(wr_stb), 0);
        chk(clk_fail == 1'b0, "R1", "fail after reset", 32'(clk_fail), 0);
        chk(spi_miso == 1'b0, "R1", "miso after reset", 32'(spi_miso), 0);
        chk(spi_miso_oe == 1'b0, "R1", "oe after reset", 32'(spi_miso_oe), 0);

        run_frame(16'h8A5C, 16);   // addr 2, sel 0, write: R3 R4 R6 R7
        run_frame(16'h7123, 16);   // addr 1, sel 1, read-only: R5
        run_frame(16'hEFFF, 16);   // addr 3, sel 1, write all ones
        run_frame(16'h2000, 16);   // addr 0, sel 1, write zero
        run_frame(16'h4ABC, 15);   // short frame: R8
        run_frame(16'hC321, 17);   // long frame: R8
        run_frame(16'h0000, 0);    // no clocks: R8
        run_frame(16'h1800, 16);   // header echo unchanged by bad frames: R7
        run_frame(16'hD555, 16);   // addr 3, sel 0, read-only
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule